// File: doc/BRIEF.md
# Paged EEPROM Write and Read Address Controller

This block sits behind a two-wire serial slave front end and owns the memory side of a small byte-addressed nonvolatile array, here modelled as registers. The front end hands it one byte-level command at a time: the start of a session (after the slave address has been matched), the address byte, a data byte to write, a request for the next read byte, or the end of the session. Every command gets a registered reply one clock later, carrying an acknowledge bit and, for reads, the byte read.

Written bytes first land in a page-sized staging buffer. The array is only updated when the session ends, and only the slots actually loaded are copied. A modelled programming interval follows, and during it new sessions are refused so that a host can poll for completion. Reads walk the whole array and roll over from the last byte to the first. Either of two protection inputs keeps the lower half of the array from being changed.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: Each command presented with `cmd_valid` high produces `rsp_valid` high for exactly one cycle, on the clock edge that accepts the command; `cmd_op` encodes session open = 0, address byte = 1, write byte = 2, read next = 3, session close = 4.
- R2: After reset all array bytes read 0xFF, the address pointer is 0, `busy` is low and `rsp_valid` is low.
- R3: An address byte sets the pointer; bits 7:4 pick the page and bits 3:0 the byte inside it, and the next write or read starts there.
- R4: Each write byte is acknowledged and advances only bits 3:0 of the pointer, rolling from 15 to 0 inside the same page; a later byte at the same slot replaces an earlier one.
- R5: The array changes only when a session closes; only slots loaded in that session change, the rest of the page keeps its contents; a session open before close drops the staged bytes without any update.
- R6: A committing close raises `busy` for exactly BUSY_CYCLES cycles; a session open while busy replies with acknowledge 0 and every later command of that session replies with acknowledge 0 and changes nothing; an open while idle replies with acknowledge 1.
- R7: Each read-next returns the byte at the pointer and then increments the full pointer, rolling from 0xFF to 0x00.
- R8: With `wp_perm` or `wp_rev` high, a session whose page is in the lower half (address below 0x80) still acknowledges its bytes, but at close the array is unchanged and `busy` stays low; the upper half is unaffected by the flags.
- R9: An address byte with no data, followed by a new session open and read-next commands, reads from the address given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 8 | Address or data byte |
| wp_perm | input | 1 | Permanent protection flag for the lower half |
| wp_rev | input | 1 | Reversible protection flag for the lower half |
| rsp_valid | output | 1 | Reply to the previous cycle's command |
| rsp_ack | output | 1 | Acknowledge bit of the reply |
| rsp_data | output | 8 | Byte read, zero for other commands |
| busy | output | 1 | Programming interval in progress |

## Verification
The bench keeps the default geometry of sixteen pages of sixteen bytes, small enough to sweep every array location through the read path and to hold a full shadow copy of the array, but shortens BUSY_CYCLES to 20 so that the exact length of the programming interval can be counted on every commit. With that geometry the in-page roll-over, the whole-array roll-over, the page straddling the protection boundary and polling during the interval all fall within a few thousand cycles.

// File: rtl/epc_pkg.sv
package epc_pkg;
   typedef enum logic [2:0] {
      OP_OPEN  = 3'd0,
      OP_ADDR  = 3'd1,
      OP_WBYTE = 3'd2,
      OP_RNEXT = 3'd3,
      OP_CLOSE = 3'd4
   } epc_op_e;
endpackage

// File: rtl/epc_busy_timer.sv
module epc_busy_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (CYCLES == 0) begin : g_none
         logic unused_in;
         assign unused_in = start ^ clk ^ rst_n;
         assign busy = 1'b0;
      end else begin : g_count
         localparam int CNT_W = $clog2(CYCLES + 1);
         logic [CNT_W-1:0] remain_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               remain_q <= '0;
            else if (start)
               remain_q <= CNT_W'(CYCLES);
            else if (remain_q != '0)
               remain_q <= remain_q - 1'b1;
         end
         assign busy = (remain_q != '0);
      end
   endgenerate
endmodule

// File: rtl/epc_page_buf.sv
module epc_page_buf #(
   parameter int PAGE_BYTES = 16,
   parameter int DATA_W     = 8,
   localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         load,
   input  logic [OFS_W-1:0]             slot,
   input  logic [DATA_W-1:0]            din,
   output logic [PAGE_BYTES*DATA_W-1:0] stage,
   output logic [PAGE_BYTES-1:0]        filled
);
   genvar s;
   generate
      for (s = 0; s < PAGE_BYTES; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               filled[s]                <= 1'b0;
               stage[s*DATA_W +: DATA_W] <= '0;
            end else if (clear) begin
               filled[s] <= 1'b0;
            end else if (load && slot == OFS_W'(s)) begin
               filled[s]                <= 1'b1;
               stage[s*DATA_W +: DATA_W] <= din;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/epc_array.sv
module epc_array #(
   parameter int PAGE_BYTES = 16,
   parameter int NUM_PAGES  = 16,
   parameter int DATA_W     = 8,
   localparam int OFS_W     = $clog2(PAGE_BYTES),
   localparam int PAGE_W    = $clog2(NUM_PAGES),
   localparam int ADDR_W    = OFS_W + PAGE_W,
   localparam int DEPTH     = PAGE_BYTES * NUM_PAGES
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit,
   input  logic [PAGE_W-1:0]            page,
   input  logic [PAGE_BYTES*DATA_W-1:0] stage,
   input  logic [PAGE_BYTES-1:0]        filled,
   input  logic [ADDR_W-1:0]            raddr,
   output logic [DATA_W-1:0]            rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (commit) begin
         for (int s = 0; s < PAGE_BYTES; s++)
            if (filled[s])
               cells[{page, OFS_W'(s)}] <= stage[s*DATA_W +: DATA_W];
      end
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
   import epc_pkg::*;
#(
   parameter int PAGE_BYTES  = 16,
   parameter int NUM_PAGES   = 16,
   parameter int DATA_W      = 8,
   parameter int BUSY_CYCLES = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              wp_perm,
   input  logic              wp_rev,
   output logic              rsp_valid,
   output logic              rsp_ack,
   output logic [DATA_W-1:0] rsp_data,
   output logic              busy
);
   localparam int OFS_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = $clog2(NUM_PAGES);
   localparam int ADDR_W = OFS_W + PAGE_W;

   generate
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two, at least 2");
      end
      if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_count
         $error("NUM_PAGES must be a power of two, at least 2");
      end
      if (ADDR_W > DATA_W) begin : g_bad_width
         $error("array address must fit in one command byte");
      end
   endgenerate

   epc_op_e            op;
   logic               sess_q;
   logic [ADDR_W-1:0]  addr_q;
   logic               take;
   logic               do_open, do_addr, do_wbyte, do_rnext, do_close;
   logic               guarded, do_commit;
   logic [PAGE_BYTES*DATA_W-1:0] stage;
   logic [PAGE_BYTES-1:0]        filled;
   logic [DATA_W-1:0]            rd_byte;

   assign op       = epc_op_e'(cmd_op);
   assign take     = cmd_valid && sess_q;
   assign do_open  = cmd_valid && (op == OP_OPEN);
   assign do_addr  = take && (op == OP_ADDR);
   assign do_wbyte = take && (op == OP_WBYTE);
   assign do_rnext = take && (op == OP_RNEXT);
   assign do_close = take && (op == OP_CLOSE);

   // lower half of the array is the protected region
   assign guarded   = (wp_perm || wp_rev) && !addr_q[ADDR_W-1];
   assign do_commit = do_close && (|filled) && !guarded;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sess_q    <= 1'b0;
         addr_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_ack   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= cmd_valid;
         rsp_data  <= '0;
         if (do_open) begin
            sess_q  <= !busy;
            rsp_ack <= !busy;
         end else if (cmd_valid) begin
            rsp_ack <= sess_q;
            if (do_addr)
               addr_q <= cmd_data[ADDR_W-1:0];
            if (do_wbyte)
               addr_q <= {addr_q[ADDR_W-1:OFS_W], addr_q[OFS_W-1:0] + 1'b1};
            if (do_rnext) begin
               addr_q   <= addr_q + 1'b1;
               rsp_data <= rd_byte;
            end
            if (do_close)
               sess_q <= 1'b0;
         end
      end
   end

   epc_page_buf #(
      .PAGE_BYTES(PAGE_BYTES),
      .DATA_W    (DATA_W)
   ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (do_open || do_addr || do_close),
      .load  (do_wbyte),
      .slot  (addr_q[OFS_W-1:0]),
      .din   (cmd_data),
      .stage (stage),
      .filled(filled)
   );

   epc_array #(
      .PAGE_BYTES(PAGE_BYTES),
      .NUM_PAGES (NUM_PAGES),
      .DATA_W    (DATA_W)
   ) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .commit(do_commit),
      .page  (addr_q[ADDR_W-1:OFS_W]),
      .stage (stage),
      .filled(filled),
      .raddr (addr_q),
      .rdata (rd_byte)
   );

   epc_busy_timer #(
      .CYCLES(BUSY_CYCLES)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(do_commit),
      .busy (busy)
   );
endmodule

// File: rtl/epc_checker.sv
module epc_checker
   import epc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int OFS_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic              wp_perm,
   input logic              wp_rev,
   input logic              rsp_valid,
   input logic              rsp_ack,
   input logic              busy,
   input logic              sess_q,
   input logic [ADDR_W-1:0] addr_q
);
   p_reply_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);

   p_reply_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid);

   p_refuse_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_OPEN && busy) |=> (rsp_valid && !rsp_ack));

   p_busy_from_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid && cmd_op == OP_CLOSE));

   p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && sess_q && cmd_op == OP_WBYTE && addr_q[OFS_W-1:0] == {OFS_W{1'b1}})
      |=> (addr_q[OFS_W-1:0] == '0 &&
           addr_q[ADDR_W-1:OFS_W] == $past(addr_q[ADDR_W-1:OFS_W])));

   p_read_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && sess_q && cmd_op == OP_RNEXT && (&addr_q)) |=> (addr_q == '0));

   p_guard_lower_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && sess_q && cmd_op == OP_CLOSE && (wp_perm || wp_rev) &&
       !addr_q[ADDR_W-1] && !busy) |=> !busy);
endmodule

bind eeprom_page_ctrl epc_checker #(
   .ADDR_W(ADDR_W),
   .OFS_W (OFS_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_op   (cmd_op),
   .wp_perm  (wp_perm),
   .wp_rev   (wp_rev),
   .rsp_valid(rsp_valid),
   .rsp_ack  (rsp_ack),
   .busy     (busy),
   .sess_q   (sess_q),
   .addr_q   (addr_q)
);

// File: tb/tb_eeprom_page_ctrl.sv
module tb_eeprom_page_ctrl;
   localparam int BUSY = 20;
   localparam logic [2:0] C_OPEN = 3'd0, C_ADDR = 3'd1, C_WB = 3'd2, C_RN = 3'd3, C_CLOSE = 3'd4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [7:0] cmd_data = '0;
   logic       wp_perm = 1'b0;
   logic       wp_rev = 1'b0;
   logic       rsp_valid, rsp_ack, busy;
   logic [7:0] rsp_data;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   logic       got_v, got_ack;
   logic [7:0] got_d;
   logic [7:0] exp_mem [256];

   always #2 clk = ~clk;

   eeprom_page_ctrl #(.BUSY_CYCLES(BUSY)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .wp_perm(wp_perm), .wp_rev(wp_rev),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data), .busy(busy)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] op, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      got_v = rsp_valid; got_ack = rsp_ack; got_d = rsp_data;
      check("R1 reply valid", {31'd0, got_v}, 1);
   endtask

   task automatic wait_idle(input bit count_it);
      int n = 0;
      while (busy) begin n++; @(negedge clk); end
      if (count_it) check("R6 busy length", n, BUSY);
   endtask

   task automatic wr_sess(input logic [7:0] a, input int n, input logic [7:0] base);
      logic [7:0] pb [16];
      bit lm [16];
      int ofs;
      bit any, prot;
      for (int i = 0; i < 16; i++) begin lm[i] = 0; pb[i] = '0; end
      send(C_OPEN, 8'h00);  check("R6 open ack idle", {31'd0, got_ack}, 1);
      send(C_ADDR, a);      check("R3 address ack", {31'd0, got_ack}, 1);
      ofs = int'(a[3:0]); any = 0;
      for (int i = 0; i < n; i++) begin
         logic [7:0] v;
         v = base + 8'(i * 13);
         send(C_WB, v);     check("R4 write byte ack", {31'd0, got_ack}, 1);
         pb[ofs] = v; lm[ofs] = 1; any = 1;
         ofs = (ofs + 1) % 16;
      end
      prot = (a < 8'h80) && (wp_perm || wp_rev);
      send(C_CLOSE, 8'h00);
      if (any && !prot) begin
         for (int i = 0; i < 16; i++)
            if (lm[i]) exp_mem[{a[7:4], 4'(i)}] = pb[i];
         wait_idle(1);
      end else begin
         check("R8 no busy without commit", {31'd0, busy}, 0);
      end
   endtask

   task automatic rd_sess(input logic [7:0] a, input int n);
      send(C_OPEN, 8'h00);  check("R9 open ack", {31'd0, got_ack}, 1);
      send(C_ADDR, a);
      send(C_OPEN, 8'h00);  check("R9 repeated open ack", {31'd0, got_ack}, 1);
      for (int k = 0; k < n; k++) begin
         logic [7:0] ea;
         ea = a + 8'(k);
         send(C_RN, 8'h00);
         check("R7 read data", {24'd0, got_d}, {24'd0, exp_mem[ea]});
      end
      send(C_CLOSE, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
      repeat (5) @(negedge clk);
      check("R2 reset reply", {31'd0, rsp_valid}, 0);
      check("R2 reset busy", {31'd0, busy}, 0);
      rst_n = 1'b1;

      // R2 / R7: immediate read from pointer 0 over the whole array and past the end
      send(C_OPEN, 8'h00);
      check("R6 open ack idle", {31'd0, got_ack}, 1);
      for (int k = 0; k < 257; k++) begin
         send(C_RN, 8'h00);
         check("R2 erased byte", {24'd0, got_d}, 32'hFF);
         check("R7 read ack", {31'd0, got_ack}, 1);
      end
      send(C_CLOSE, 8'h00);
      check("R8 no commit on read", {31'd0, busy}, 0);

      // R3 / R4: 20 bytes into page 3, starting mid-page, overrun wraps in page
      wr_sess(8'h3A, 20, 8'h40);
      rd_sess(8'h30, 16);
      rd_sess(8'h2F, 1);
      rd_sess(8'h40, 1);

      // R5: partial page keeps other bytes
      wr_sess(8'h55, 3, 8'hC1);
      rd_sess(8'h50, 16);

      // R6: refused session while programming, pointer must stay at 0x92
      send(C_OPEN, 8'h00);
      send(C_ADDR, 8'h90);
      send(C_WB, 8'h12);
      send(C_WB, 8'h34);
      send(C_CLOSE, 8'h00);
      exp_mem[8'h90] = 8'h12; exp_mem[8'h91] = 8'h34;
      check("R6 busy after close", {31'd0, busy}, 1);
      send(C_OPEN, 8'h00);  check("R6 open refused", {31'd0, got_ack}, 0);
      send(C_ADDR, 8'h3A);  check("R6 address refused", {31'd0, got_ack}, 0);
      send(C_WB, 8'h77);    check("R6 byte refused", {31'd0, got_ack}, 0);
      send(C_RN, 8'h00);    check("R6 read refused", {31'd0, got_ack}, 0);
      send(C_CLOSE, 8'h00);
      wait_idle(0);
      send(C_OPEN, 8'h00);  check("R6 open ack after busy", {31'd0, got_ack}, 1);
      send(C_RN, 8'h00);    check("R6 pointer untouched", {24'd0, got_d}, {24'd0, exp_mem[8'h92]});
      send(C_CLOSE, 8'h00);
      rd_sess(8'h90, 4);

      // R5: new open before close drops staged bytes
      send(C_OPEN, 8'h00);
      send(C_ADDR, 8'h70);
      send(C_WB, 8'h11);
      send(C_OPEN, 8'h00);  check("R5 repeated open ack", {31'd0, got_ack}, 1);
      send(C_RN, 8'h00);    check("R5 read after drop", {24'd0, got_d}, {24'd0, exp_mem[8'h71]});
      send(C_CLOSE, 8'h00);
      check("R5 no busy after drop", {31'd0, busy}, 0);
      rd_sess(8'h70, 1);

      // R8: protection flags on lower half only
      wp_perm = 1'b1;
      wr_sess(8'h10, 4, 8'h21);
      rd_sess(8'h10, 4);
      wr_sess(8'hA0, 4, 8'h33);
      rd_sess(8'hA0, 4);
      wp_perm = 1'b0; wp_rev = 1'b1;
      wr_sess(8'h7F, 2, 8'h5A);
      rd_sess(8'h70, 16);
      wp_rev = 1'b0;
      wr_sess(8'h7F, 2, 8'h5A);
      rd_sess(8'h70, 16);

      // R7: full-pointer rollover and final sweep
      rd_sess(8'hFE, 3);
      rd_sess(8'h00, 256);

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule